// File: doc/BRIEF.md
# Corrected-Error Threshold Interrupt Unit

This unit keeps the error-reporting state of a single error bank. Every corrected-error pulse from the bank raises a 15-bit running count that lives inside a 64-bit status word. Software programs a 15-bit threshold and a bank enable in a control word. When an error moves the count onto the threshold, the unit emits a one-cycle overflow event toward the threshold entry of the local interrupt controller. The event can be delivered to several processor targets at once when the erroring resource is shared between them.

The whole feature is dormant after reset. Software first sets a global capability/enable bit, then reads the threshold. A zero threshold means the bank has no threshold support, so software writes a threshold of one. Software then sets the bank enable. The count saturates instead of wrapping, and any write to the status word clears it.

All pins are plain control and status signals. No interface of this block carries a data stream, so there is no back-pressure. The register port accepts a write in every cycle. Its read data is combinational from the address. Error pulses are counted in the cycle they arrive. Event outputs are single-cycle pulses with no acknowledge.

Top module: `ce_thresh_irq`

## Requirements
- R1: After reset, the global enable, the bank enable, the threshold and the count are all zero, and no target sees an event.
- R2: Address 0 is the global capability register. Only bit 10 (the global enable) is writable, and all other bits read zero. Address 3 reads zero and ignores writes.
- R3: Address 1 is the bank control register. Bits 14:0 hold the threshold and bit 30 holds the bank enable. All other bits read zero.
- R4: Address 2 is the bank status register. The count reads at bits 52:38 and all other bits read zero. Any write to address 2 clears the count in the next cycle.
- R5: Each cycle with `err_pulse` high raises the count by one, visible from the following cycle.
- R6: The count saturates at 0x7FFF. A further error leaves it unchanged and produces no event.
- R7: An event fires when an error makes the count equal to the threshold. It is a single-cycle pulse that appears in the same cycle as the new count. It does not repeat while the count stays equal, and it stops once the count moves past the threshold.
- R8: No event fires unless both the global enable and the bank enable are 1. Counting continues regardless of either enable.
- R9: A zero threshold never produces an event. Writing a threshold equal to the present count does not produce an event.
- R10: An event reaches every target whose bit is set in `tgt_mask`, all in the same cycle. No event reaches a target whose bit is clear.
- R11: A status write and an error in the same cycle leave the count at 1. This counts as the count becoming 1 for R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| err_pulse | input | 1 | One corrected error per high cycle |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 global, 1 control, 2 status) |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data for `reg_addr` |
| tgt_mask | input | NUM_TGT | Processor targets sharing this bank |
| irq_evt | output | NUM_TGT | Per-target overflow event pulse |

## Verification
The hardest condition to reach from the ports is the saturated count. Reaching it takes 32767 errors, and at that point a matching threshold must fire exactly once while the next error stays silent. The bench sets the threshold to 0x7FFF, holds `err_pulse` high for 32766 cycles, and then issues the final error on its own. It checks the event on all masked targets at that error and checks for silence on the one after. The same-cycle collision of a status clear with an error is reached by driving a status write and `err_pulse` together in one table row.

// File: rtl/cti_pkg.sv
package cti_pkg;
  localparam int REG_W       = 64;
  localparam int CNT_W       = 15;
  localparam int CNT_LSB     = 38;
  localparam int THR_LSB     = 0;
  localparam int BEN_BIT     = 30;
  localparam int GEN_BIT     = 10;
  localparam int ADDR_W      = 2;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  typedef enum logic [ADDR_W-1:0] {
    A_GLB  = 2'd0,
    A_CTL  = 2'd1,
    A_STS  = 2'd2,
    A_NONE = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/cti_regs.sv
module cti_regs
  import cti_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [REG_W-1:0]    reg_wdata,
  input  logic [CNT_W-1:0]    cnt,
  output logic [REG_W-1:0]    reg_rdata,
  output logic                glb_en,
  output logic                bank_en,
  output logic [CNT_W-1:0]    thr,
  output logic                sts_clr
);
  logic unused_wdata;
  assign unused_wdata = ^reg_wdata;

  logic wr_glb, wr_ctl;
  assign wr_glb  = reg_wr && (reg_addr == A_GLB);
  assign wr_ctl  = reg_wr && (reg_addr == A_CTL);
  assign sts_clr = reg_wr && (reg_addr == A_STS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glb_en  <= 1'b0;
      bank_en <= 1'b0;
      thr     <= '0;
    end else begin
      if (wr_glb) glb_en <= reg_wdata[GEN_BIT];
      if (wr_ctl) begin
        bank_en <= reg_wdata[BEN_BIT];
        thr     <= reg_wdata[THR_LSB +: CNT_W];
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_GLB: reg_rdata[GEN_BIT] = glb_en;
      A_CTL: begin
        reg_rdata[BEN_BIT]         = bank_en;
        reg_rdata[THR_LSB +: CNT_W] = thr;
      end
      A_STS:   reg_rdata[CNT_LSB +: CNT_W] = cnt;
      default: reg_rdata = '0;
    endcase
  end

  // R3: control fields follow the last control write
  a_r3_ctl_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctl |=> (thr == $past(reg_wdata[THR_LSB +: CNT_W])) && (bank_en == $past(reg_wdata[BEN_BIT])));
  // R2: global enable changes only on a global write
  a_r2_glb_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_glb |=> $stable(glb_en));
endmodule

// File: rtl/cti_counter.sv
module cti_counter
  import cti_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             err,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cnt_d,
  output logic             step
);
  logic at_max;
  assign at_max = (cnt == CNT_MAX);
  assign step   = err && (clr || !at_max);

  always_comb begin
    if (clr)       cnt_d = err ? CNT_W'(1) : '0;
    else if (step) cnt_d = CNT_W'(cnt + 1'b1);
    else           cnt_d = cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end

  // R5: one error adds one
  a_r5_increment: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !clr && !at_max) |=> cnt == CNT_W'($past(cnt) + 1'b1));
  // R6: saturated count holds
  a_r6_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !clr && at_max) |=> cnt == CNT_MAX);
  // R4: a clear alone empties the count
  a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !err) |=> cnt == '0);
  // R11: clear with error leaves one
  a_r11_clear_err: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && err) |=> cnt == CNT_W'(1));
  // R5: count never moves without an error or a clear
  a_r5_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!err && !clr) |=> $stable(cnt));
endmodule

// File: rtl/cti_match.sv
module cti_match
  import cti_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             err,
  input  logic [CNT_W-1:0] cnt_d,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] thr,
  input  logic             glb_en,
  input  logic             bank_en,
  output logic             evt
);
  logic armed, hit;
  assign armed = glb_en && bank_en && (thr != '0);
  assign hit   = step && (cnt_d == thr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt <= 1'b0;
    else        evt <= armed && hit;
  end

  // R7: an event coincides with the count sitting on the threshold
  a_r7_on_match: assert property (@(posedge clk) disable iff (!rst_n)
    evt |-> cnt == $past(thr));
  // R7: an event is always caused by an error
  a_r7_cause: assert property (@(posedge clk) disable iff (!rst_n)
    evt |-> $past(err));
  // R8: both enables gate the event
  a_r8_gate: assert property (@(posedge clk) disable iff (!rst_n)
    evt |-> $past(glb_en && bank_en));
  // R9: a zero threshold never fires
  a_r9_zero_thr: assert property (@(posedge clk) disable iff (!rst_n)
    evt |-> $past(thr) != '0);
endmodule

// File: rtl/cti_fanout.sv
module cti_fanout #(
  parameter int NUM_TGT = 4
) (
  input  logic               evt,
  input  logic [NUM_TGT-1:0] tgt_mask,
  output logic [NUM_TGT-1:0] irq_evt
);
  for (genvar g = 0; g < NUM_TGT; g++) begin : g_tgt
    assign irq_evt[g] = evt && tgt_mask[g];
  end

  // R10: events only go to masked targets, never to a target without one
  always_comb begin
    a_r10_masked: assert ((irq_evt & ~tgt_mask) == '0);
  end
endmodule

// File: rtl/ce_thresh_irq.sv
module ce_thresh_irq
  import cti_pkg::*;
#(
  parameter int NUM_TGT = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                err_pulse,
  input  logic                reg_wr,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [REG_W-1:0]    reg_wdata,
  output logic [REG_W-1:0]    reg_rdata,
  input  logic [NUM_TGT-1:0]  tgt_mask,
  output logic [NUM_TGT-1:0]  irq_evt
);
  logic             glb_en, bank_en, sts_clr, step, evt;
  logic [CNT_W-1:0] thr, cnt, cnt_d;

  cti_regs u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .cnt(cnt), .reg_rdata(reg_rdata),
    .glb_en(glb_en), .bank_en(bank_en), .thr(thr), .sts_clr(sts_clr)
  );

  cti_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .err(err_pulse), .clr(sts_clr),
    .cnt(cnt), .cnt_d(cnt_d), .step(step)
  );

  cti_match u_match (
    .clk(clk), .rst_n(rst_n), .step(step), .err(err_pulse), .cnt_d(cnt_d),
    .cnt(cnt), .thr(thr), .glb_en(glb_en), .bank_en(bank_en), .evt(evt)
  );

  cti_fanout #(.NUM_TGT(NUM_TGT)) u_fan (
    .evt(evt), .tgt_mask(tgt_mask), .irq_evt(irq_evt)
  );

  // R7: no back-to-back event without a fresh error in between
  a_r7_single: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && !err_pulse) |=> !evt);
endmodule

// File: tb/tb_ce_thresh_irq.sv
module tb_ce_thresh_irq;
  localparam int CLK_P = 10;
  localparam int NT    = 4;

  typedef struct packed {
    logic        wr;
    logic        err;
    logic [1:0]  addr;
    logic [63:0] wd;
    logic [3:0]  eirq;
    logic [63:0] erd;
  } vec_t;

  localparam logic [63:0] C1 = 64'h0000_0040_0000_0000; // count 1 at bits 52:38
  localparam logic [63:0] C2 = 64'h0000_0080_0000_0000;
  localparam logic [63:0] C3 = 64'h0000_00C0_0000_0000;
  localparam logic [63:0] C4 = 64'h0000_0100_0000_0000;

  localparam int NV = 24;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 1'b0, 2'd0, 64'hFFFF_FFFF_FFFF_FFFF, 4'b0000, 64'h400},         // R2 only bit 10
    '{1'b1, 1'b0, 2'd1, 64'hFFFF_FFFF_FFFF_FFFF, 4'b0000, 64'h4000_7FFF},   // R3 fields
    '{1'b1, 1'b0, 2'd1, 64'h4000_0003,           4'b0000, 64'h4000_0003},   // R3 thr 3 en
    '{1'b0, 1'b1, 2'd2, 64'h0,                   4'b0000, C1},              // R5
    '{1'b0, 1'b1, 2'd2, 64'h0,                   4'b0000, C2},              // R5
    '{1'b0, 1'b1, 2'd2, 64'h0,                   4'b0101, C3},              // R7 fire
    '{1'b0, 1'b1, 2'd2, 64'h0,                   4'b0000, C4},              // R7 no repeat
    '{1'b1, 1'b0, 2'd2, 64'hDEAD,                4'b0000, 64'h0},           // R4 clear
    '{1'b1, 1'b0, 2'd1, 64'h2,                   4'b0000, 64'h2},           // R3 en off
    '{1'b0, 1'b1, 2'd2, 64'h0,                   4'b0000, C1},              // R8
    '{1'b0, 1'b1, 2'd2, 64'h0,                   4'b0000, C2},              // R8 bank off
    '{1'b1, 1'b1, 2'd2, 64'h0,                   4'b0000, C1},              // R11 disabled
    '{1'b1, 1'b0, 2'd1, 64'h4000_0001,           4'b0000, 64'h4000_0001},   // R3
    '{1'b1, 1'b1, 2'd2, 64'h0,                   4'b0101, C1},              // R11 fires
    '{1'b1, 1'b0, 2'd0, 64'h0,                   4'b0000, 64'h0},           // R2 global off
    '{1'b1, 1'b0, 2'd2, 64'h0,                   4'b0000, 64'h0},           // R4
    '{1'b0, 1'b1, 2'd2, 64'h0,                   4'b0000, C1},              // R8 global off
    '{1'b1, 1'b0, 2'd1, 64'h4000_0000,           4'b0000, 64'h4000_0000},   // R9 thr 0
    '{1'b1, 1'b0, 2'd0, 64'h400,                 4'b0000, 64'h400},         // R2
    '{1'b1, 1'b0, 2'd2, 64'h0,                   4'b0000, 64'h0},           // R4
    '{1'b0, 1'b1, 2'd2, 64'h0,                   4'b0000, C1},              // R9 zero thr
    '{1'b1, 1'b0, 2'd1, 64'h4000_0001,           4'b0000, 64'h4000_0001},   // R9 thr = count
    '{1'b0, 1'b0, 2'd2, 64'h0,                   4'b0000, C1},              // R9 still silent
    '{1'b1, 1'b0, 2'd3, 64'hFFFF,                4'b0000, 64'h0}            // R2 addr 3
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          err_pulse = 1'b0;
  logic          reg_wr = 1'b0;
  logic [1:0]    reg_addr = '0;
  logic [63:0]   reg_wdata = '0;
  logic [63:0]   reg_rdata;
  logic [NT-1:0] tgt_mask = 4'b0101;
  logic [NT-1:0] irq_evt;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  ce_thresh_irq #(.NUM_TGT(NT)) dut (
    .clk(clk), .rst_n(rst_n), .err_pulse(err_pulse), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tgt_mask(tgt_mask), .irq_evt(irq_evt)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic wr, input logic err, input logic [1:0] a, input logic [63:0] d);
    reg_wr = wr; err_pulse = err; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; err_pulse = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    int bad_irq;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset values
    reg_addr = 2'd0; #1 chk("R1 glb", reg_rdata, 64'h0);
    reg_addr = 2'd1; #1 chk("R1 ctl", reg_rdata, 64'h0);
    reg_addr = 2'd2; #1 chk("R1 sts", reg_rdata, 64'h0);
    chk("R1 irq", 64'(irq_evt), 64'h0);
    @(negedge clk);

    // table walk
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].wr, VEC[i].err, VEC[i].addr, VEC[i].wd);
      chk($sformatf("row%0d irq", i), 64'(irq_evt), 64'(VEC[i].eirq));
      chk($sformatf("row%0d rdata", i), reg_rdata, VEC[i].erd);
    end

    // R6 R10: saturation with all targets
    tgt_mask = 4'b1111;
    drive(1'b1, 1'b0, 2'd1, 64'h4000_7FFF);
    drive(1'b1, 1'b0, 2'd2, 64'h0);
    bad_irq = 0;
    err_pulse = 1'b1;
    for (int k = 0; k < 32766; k++) begin
      @(negedge clk);
      if (irq_evt != '0) bad_irq++;
    end
    err_pulse = 1'b0;
    chk("R7 no early event", 64'(bad_irq), 64'h0);
    chk("R5 count 7FFE", reg_rdata, 64'(15'h7FFE) << 38);
    drive(1'b0, 1'b1, 2'd2, 64'h0);
    chk("R10 all targets", 64'(irq_evt), 64'hF);
    chk("R6 count max", reg_rdata, 64'(15'h7FFF) << 38);
    drive(1'b0, 1'b1, 2'd2, 64'h0);
    chk("R6 no event at saturation", 64'(irq_evt), 64'h0);
    chk("R6 holds max", reg_rdata, 64'(15'h7FFF) << 38);

    // R10: single target after clear
    tgt_mask = 4'b0010;
    drive(1'b1, 1'b0, 2'd1, 64'h4000_0001);
    drive(1'b1, 1'b0, 2'd2, 64'h0);
    drive(1'b0, 1'b1, 2'd2, 64'h0);
    chk("R10 one target", 64'(irq_evt), 64'h2);

    // R1: mid-run reset
    drive(1'b0, 1'b1, 2'd2, 64'h0);
    rst_n = 1'b0;
    #1;
    reg_addr = 2'd0; #1 chk("R1 glb after reset", reg_rdata, 64'h0);
    reg_addr = 2'd1; #1 chk("R1 ctl after reset", reg_rdata, 64'h0);
    reg_addr = 2'd2; #1 chk("R1 sts after reset", reg_rdata, 64'h0);
    chk("R1 irq after reset", 64'(irq_evt), 64'h0);
    @(negedge clk);
    rst_n = 1'b1;
    drive(1'b0, 1'b1, 2'd2, 64'h0);
    chk("R8 silent after reset", 64'(irq_evt), 64'h0);
    chk("R5 counts after reset", reg_rdata, C1);

    finish_run();
  end
endmodule